// File: doc/BRIEF.md
# CAN Transmit Mailbox Arbiter

This block decides which of eight transmit mailboxes goes to the CAN transmit framer next. The host raises a one-cycle request pulse for a mailbox once its identifier, format bits, length and payload are loaded. That pulse marks the mailbox as pending. The arbiter picks one pending mailbox while the framer is idle and puts that mailbox's fields on the framer side. It then holds this grant until the framer reports one of three outcomes: the frame went out, arbitration on the bus was lost, or a transmit error occurred.

The selection policy is set by a mode input and may change at run time. In fixed-priority mode the lowest-numbered pending mailbox wins. In round-robin mode the search begins at the mailbox after the last one granted and wraps around. The host can cancel a pending mailbox with a one-cycle abort pulse. If that mailbox is on the wire at the time, the cancel waits for the framer's outcome and the frame is never cut short. A successful send clears the pending flag. It also gives a one-cycle interrupt pulse on that mailbox's line, but only if interrupts are enabled for that mailbox.

Top module: `tx_mailbox_arbiter`

## Requirements
- R1: After reset, `pending`, `tx_irq` and `fr_valid` are all zero.
- R2: With `rr_mode` low, a new grant always goes to the lowest-numbered eligible mailbox, so mailbox 0 has the highest priority.
- R3: With `rr_mode` high, the search starts at the mailbox one above the last granted index and wraps from 7 to 0. After reset the last granted index counts as 7.
- R4: A pulse on `req_set[i]` makes `pending[i]` high from the next cycle. A mailbox is granted only while it is pending.
- R5: A pulse on `abort_set[i]` for a mailbox that is not being sent clears `pending[i]` on the next cycle. The abort wins over a request in the same cycle, and that mailbox cannot be granted in that cycle.
- R6: An abort of the mailbox being sent leaves `pending` set until the framer reports an outcome. After any outcome the flag is cleared.
- R7: An `fr_done` pulse while `fr_valid` is high clears the granted mailbox's pending bit on the next cycle and drops `fr_valid`.
- R8: An `fr_lost` or `fr_err` pulse while `fr_valid` is high drops `fr_valid` but leaves the pending bit set, unless an abort is outstanding. The mailbox then takes part in the next selection.
- R9: `tx_irq[i]` pulses for exactly one cycle, the cycle after an `fr_done` for mailbox i, and only if `irq_en[i]` was high with that done.
- R10: A grant is made only while `fr_valid` is low. `fr_valid` and `fr_buf` hold steady until the framer reports an outcome. An outcome pulse while `fr_valid` is low has no effect.
- R11: While `fr_valid` is high, `fr_id`, `fr_ide`, `fr_rtr`, `fr_dlc` and `fr_data` equal the fields of mailbox `fr_buf`. Mailbox i's identifier sits at bits i*29 upward of `mb_id`, its length at i*4 of `mb_dlc`, and its payload at i*64 of `mb_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rr_mode | input | 1 | 1 selects round robin, 0 selects fixed priority |
| req_set | input | 8 | Per-mailbox transmit request pulse |
| abort_set | input | 8 | Per-mailbox abort pulse |
| irq_en | input | 8 | Per-mailbox transmit interrupt enable |
| mb_id | input | 232 | Identifiers, 29 bits per mailbox |
| mb_ide | input | 8 | Extended-format flag per mailbox |
| mb_rtr | input | 8 | Remote-request flag per mailbox |
| mb_dlc | input | 32 | Length codes, 4 bits per mailbox |
| mb_data | input | 512 | Payloads, 64 bits per mailbox |
| fr_done | input | 1 | Framer: frame sent |
| fr_lost | input | 1 | Framer: bus arbitration lost |
| fr_err | input | 1 | Framer: transmit error |
| fr_valid | output | 1 | A mailbox is granted to the framer |
| fr_buf | output | 3 | Index of the granted mailbox |
| fr_id | output | 29 | Identifier of the granted mailbox |
| fr_ide | output | 1 | Extended flag of the granted mailbox |
| fr_rtr | output | 1 | Remote flag of the granted mailbox |
| fr_dlc | output | 4 | Length of the granted mailbox |
| fr_data | output | 64 | Payload of the granted mailbox |
| pending | output | 8 | Per-mailbox request-pending status |
| tx_irq | output | 8 | Per-mailbox transmit-complete interrupt pulse |

## Verification
Directed runs first load three mailboxes at once in fixed mode, which shows whether the lowest index wins, and then the same kind of set in round-robin mode, which shows whether the rotation starts after the last grant rather than at zero. Further directed steps abort an idle mailbox and abort the mailbox in flight, which separates the immediate cancel from the deferred one. They also mix done, lost and error outcomes, which separates clearing from retrying. A completion with the enable off checks the interrupt gating. The constrained-random phase toggles the mode and the enables and scatters requests, aborts and outcomes with random framer latency, including outcome pulses while idle. A bench model checks every cycle, which exposes ordering faults that appear only when the mode changes while the framer is busy.

// File: rtl/tx_mailbox_arbiter.sv
module tx_mailbox_arbiter #(
  parameter int NBUF = 8,
  parameter int IDW  = 29,
  parameter int DLCW = 4,
  parameter int DW   = 64,
  localparam int IW  = $clog2(NBUF)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rr_mode,
  input  logic [NBUF-1:0]      req_set,
  input  logic [NBUF-1:0]      abort_set,
  input  logic [NBUF-1:0]      irq_en,
  input  logic [NBUF*IDW-1:0]  mb_id,
  input  logic [NBUF-1:0]      mb_ide,
  input  logic [NBUF-1:0]      mb_rtr,
  input  logic [NBUF*DLCW-1:0] mb_dlc,
  input  logic [NBUF*DW-1:0]   mb_data,
  input  logic                 fr_done,
  input  logic                 fr_lost,
  input  logic                 fr_err,
  output logic                 fr_valid,
  output logic [IW-1:0]        fr_buf,
  output logic [IDW-1:0]       fr_id,
  output logic                 fr_ide,
  output logic                 fr_rtr,
  output logic [DLCW-1:0]      fr_dlc,
  output logic [DW-1:0]        fr_data,
  output logic [NBUF-1:0]      pending,
  output logic [NBUF-1:0]      tx_irq
);

  logic            busy, hold, found;
  logic [IW-1:0]   gnt, last, base, pick;
  logic [NBUF-1:0] pend_q, irq_q;

  wire             resp     = busy & (fr_done | fr_lost | fr_err);
  wire [NBUF-1:0]  gmask    = busy ? (NBUF'(1) << gnt) : '0;
  wire             hold_eff = hold | (busy & abort_set[gnt]);
  wire [NBUF-1:0]  clr      = (resp & (fr_done | hold_eff)) ? gmask : '0;
  wire [NBUF-1:0]  cand     = pend_q & ~abort_set;

  always_comb begin
    base  = rr_mode ? IW'((int'(last) + 1) % NBUF) : '0;
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < NBUF; k++) begin
      if (!found && cand[(int'(base) + k) % NBUF]) begin
        found = 1'b1;
        pick  = IW'((int'(base) + k) % NBUF);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      hold   <= 1'b0;
      gnt    <= '0;
      last   <= IW'(NBUF - 1);
      pend_q <= '0;
      irq_q  <= '0;
    end else begin
      pend_q <= ((pend_q & ~clr) | req_set) & ~(abort_set & ~gmask);
      irq_q  <= (resp & fr_done) ? (gmask & irq_en) : '0;
      if (resp) begin
        busy <= 1'b0;
        hold <= 1'b0;
      end else if (busy) begin
        if (abort_set[gnt]) hold <= 1'b1;
      end else if (found) begin
        busy <= 1'b1;
        gnt  <= pick;
        last <= pick;
        hold <= 1'b0;
      end
    end
  end

  assign fr_valid = busy;
  assign fr_buf   = gnt;
  assign fr_id    = mb_id[gnt*IDW +: IDW];
  assign fr_ide   = mb_ide[gnt];
  assign fr_rtr   = mb_rtr[gnt];
  assign fr_dlc   = mb_dlc[gnt*DLCW +: DLCW];
  assign fr_data  = mb_data[gnt*DW +: DW];
  assign pending  = pend_q;
  assign tx_irq   = irq_q;

endmodule

// File: rtl/tx_mailbox_arbiter_chk.sv
module tx_mailbox_arbiter_chk #(
  parameter int NBUF = 8,
  localparam int IW  = $clog2(NBUF)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rr_mode,
  input logic [NBUF-1:0] abort_set,
  input logic [NBUF-1:0] irq_en,
  input logic            fr_done,
  input logic            fr_lost,
  input logic            fr_err,
  input logic            fr_valid,
  input logic [IW-1:0]   fr_buf,
  input logic [NBUF-1:0] pending,
  input logic [NBUF-1:0] tx_irq
);

  wire [NBUF-1:0] fly  = fr_valid ? (NBUF'(1) << fr_buf) : '0;
  wire [NBUF-1:0] low  = (NBUF'(1) << fr_buf) - NBUF'(1);
  wire            outc = fr_done | fr_lost | fr_err;

  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fr_valid && !outc |=> fr_valid && $stable(fr_buf)); // R10

  AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fr_valid) |-> pending[fr_buf]); // R4

  AST_FIXED_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fr_valid) && $past(!rr_mode) |-> (($past(pending & ~abort_set) & low) == '0)); // R2

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    |(abort_set & ~fly) |=> ((pending & $past(abort_set & ~fly)) == '0)); // R5

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    |tx_irq |-> ((tx_irq & ~$past(irq_en)) == '0)); // R9

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    |tx_irq |-> $past(fr_valid && fr_done) && (tx_irq == (NBUF'(1) << $past(fr_buf)))); // R9

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_irq)); // R9

endmodule

bind tx_mailbox_arbiter tx_mailbox_arbiter_chk #(.NBUF(NBUF)) u_chk (
  .clk(clk), .rst_n(rst_n), .rr_mode(rr_mode), .abort_set(abort_set),
  .irq_en(irq_en), .fr_done(fr_done), .fr_lost(fr_lost), .fr_err(fr_err),
  .fr_valid(fr_valid), .fr_buf(fr_buf), .pending(pending), .tx_irq(tx_irq)
);

// File: tb/tb_tx_mailbox_arbiter.sv
module tb_tx_mailbox_arbiter;
  localparam int PERIOD = 10;
  localparam int NB = 8;

  logic clk = 0, rst_n = 0, rr_mode = 0;
  logic [NB-1:0] req = 0, abt = 0, en = 0, mb_ide, mb_rtr;
  logic [NB*29-1:0] mb_id;
  logic [NB*4-1:0] mb_dlc;
  logic [NB*64-1:0] mb_data;
  logic done = 0, lost = 0, err = 0;
  logic fr_valid, fr_ide, fr_rtr;
  logic [2:0] fr_buf;
  logic [28:0] fr_id;
  logic [3:0] fr_dlc;
  logic [63:0] fr_data;
  logic [NB-1:0] pending, tx_irq;

  int nchk = 0, nfail = 0;
  bit [7:0] m_pend = 0, m_irq = 0;
  bit m_busy = 0, m_hold = 0, m_gmode = 0;
  int m_g = 0, m_last = 7;

  always #(PERIOD/2) clk = ~clk;

  tx_mailbox_arbiter dut (
    .clk(clk), .rst_n(rst_n), .rr_mode(rr_mode), .req_set(req), .abort_set(abt),
    .irq_en(en), .mb_id(mb_id), .mb_ide(mb_ide), .mb_rtr(mb_rtr), .mb_dlc(mb_dlc),
    .mb_data(mb_data), .fr_done(done), .fr_lost(lost), .fr_err(err),
    .fr_valid(fr_valid), .fr_buf(fr_buf), .fr_id(fr_id), .fr_ide(fr_ide),
    .fr_rtr(fr_rtr), .fr_dlc(fr_dlc), .fr_data(fr_data), .pending(pending), .tx_irq(tx_irq)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int pick_next(input bit [7:0] cand, input bit rr, input int last);
    int base = rr ? (last + 1) % NB : 0;
    for (int k = 0; k < NB; k++)
      if (cand[(base + k) % NB]) return (base + k) % NB;
    return -1;
  endfunction

  task automatic model_update();
    bit resp = m_busy && (done || lost || err);
    bit [7:0] gm = m_busy ? 8'(1 << m_g) : 8'h0;
    bit he = m_hold || (m_busy && abt[m_g]);
    bit [7:0] clr = (resp && (done || he)) ? gm : 8'h0;
    int p;
    m_irq = (resp && done) ? (gm & en) : 8'h0;
    if (resp) begin
      m_busy = 0; m_hold = 0;
    end else if (m_busy) begin
      if (abt[m_g]) m_hold = 1;
    end else begin
      p = pick_next(m_pend & ~abt, rr_mode, m_last);
      if (p >= 0) begin
        m_busy = 1; m_g = p; m_last = p; m_hold = 0; m_gmode = rr_mode;
      end
    end
    m_pend = ((m_pend & ~clr) | req) & ~(abt & ~gm);
  endtask

  task automatic compare();
    chk(pending == m_pend, "R4", "pending", 64'(pending), 64'(m_pend));
    chk(fr_valid == m_busy, "R10", "fr_valid", 64'(fr_valid), 64'(m_busy));
    chk(tx_irq == m_irq, "R9", "tx_irq", 64'(tx_irq), 64'(m_irq));
    if (m_busy) begin
      chk(fr_buf == 3'(m_g), m_gmode ? "R3" : "R2", "fr_buf", 64'(fr_buf), 64'(m_g));
      chk(fr_id == mb_id[m_g*29 +: 29] && fr_dlc == mb_dlc[m_g*4 +: 4] &&
          fr_data == mb_data[m_g*64 +: 64] && fr_ide == mb_ide[m_g] && fr_rtr == mb_rtr[m_g],
          "R11", "fields", 64'(fr_id), 64'(mb_id[m_g*29 +: 29]));
    end
  endtask

  task automatic step(input bit [7:0] r, input bit [7:0] a, input bit d, input bit l, input bit e);
    req = r; abt = a; done = d; lost = l; err = e;
    model_update();
    @(posedge clk);
    @(negedge clk);
    req = 0; abt = 0; done = 0; lost = 0; err = 0;
    compare();
  endtask

  initial begin
    #(PERIOD * 200000);
    nfail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int lat, held;
    void'($urandom(32'h1c4a7e55));
    for (int i = 0; i < NB; i++) begin
      mb_id[i*29 +: 29] = 29'($urandom);
      mb_dlc[i*4 +: 4] = 4'($urandom);
      mb_data[i*64 +: 64] = {$urandom, $urandom};
      mb_ide[i] = 1'($urandom);
      mb_rtr[i] = 1'($urandom);
    end
    repeat (3) @(negedge clk);
    chk(pending == 0 && tx_irq == 0 && fr_valid == 0, "R1", "reset outputs",
        {pending, tx_irq, 7'h0, fr_valid}, 64'h0);
    rst_n = 1;
    @(negedge clk);
    compare();

    en = 8'hFF; rr_mode = 0;
    step(8'hA4, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    chk(fr_valid && fr_buf == 2, "R2", "fixed grant", 64'(fr_buf), 64'd2);
    step(0, 0, 1, 0, 0);
    chk(pending == 8'hA0, "R7", "done clears", 64'(pending), 64'hA0);
    chk(tx_irq == 8'h04, "R9", "irq on done", 64'(tx_irq), 64'h04);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0);
    chk(pending == 8'hA0 && !fr_valid, "R8", "lost keeps", 64'(pending), 64'hA0);
    step(0, 0, 0, 0, 0);
    chk(fr_buf == 5, "R8", "regrant after lost", 64'(fr_buf), 64'd5);
    held = fr_buf;
    step(0, 8'h20, 0, 0, 0);
    chk(pending == 8'hA0, "R6", "abort deferred", 64'(pending), 64'hA0);
    step(0, 0, 0, 0, 0);
    chk(fr_valid && fr_buf == 3'(held), "R10", "grant stable", 64'(fr_buf), 64'(held));
    step(0, 0, 0, 1, 0);
    chk(pending == 8'h80, "R6", "abort after lost", 64'(pending), 64'h80);
    step(0, 8'h80, 0, 0, 0);
    chk(pending == 0 && !fr_valid, "R5", "idle abort", 64'(pending), 64'h0);
    step(0, 0, 1, 0, 0);
    chk(!fr_valid && tx_irq == 0, "R10", "idle outcome ignored", 64'(tx_irq), 64'h0);

    rr_mode = 1;
    step(8'h23, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    chk(fr_buf == 0, "R3", "rr wraps", 64'(fr_buf), 64'd0);
    step(0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0);
    chk(fr_buf == 1, "R3", "rr next", 64'(fr_buf), 64'd1);
    step(0, 0, 0, 0, 1);
    chk(pending == 8'h22, "R8", "error keeps", 64'(pending), 64'h22);
    step(0, 0, 0, 0, 0);
    chk(fr_buf == 5, "R3", "rr after error", 64'(fr_buf), 64'd5);
    step(0, 0, 1, 0, 0);
    en = 8'h00;
    step(0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    chk(tx_irq == 0 && pending == 0, "R9", "irq gated", 64'(tx_irq), 64'h0);

    lat = 0;
    for (int c = 0; c < 3000; c++) begin
      bit [7:0] r, a;
      bit d, l, e;
      int o;
      if ($urandom % 150 == 0) rr_mode = ~rr_mode;
      if ($urandom % 100 == 0) en = 8'($urandom);
      r = ($urandom % 3 == 0) ? 8'(1 << ($urandom % 8)) : 8'h0;
      a = ($urandom % 12 == 0) ? 8'(1 << ($urandom % 8)) : 8'h0;
      d = 0; l = 0; e = 0;
      if (m_busy) begin
        if (lat == 0) begin
          o = $urandom % 20;
          if (o < 12) d = 1; else if (o < 17) l = 1; else e = 1;
          lat = $urandom % 4;
        end else lat--;
      end else if ($urandom % 25 == 0) d = 1;
      step(r, a, d, l, e);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule